// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores incoming frames in a circular region of a local byte-addressed buffer memory. The memory is split into pages whose size is a power of two, 256 bytes by default. Software sets aside a contiguous run of pages for the ring through a small register write port. It sets the first page of the ring, the page just past the last one, the oldest page it has not read yet (the boundary), and the page where the next frame will go (the current page).

For each frame, the block writes the data bytes into consecutive pages. The first data byte goes at offset 4 of the frame's first page. When the ring has taken the whole frame, the block goes back to that first page and writes a 4-byte link header there. The header holds the receive status, the page where the next frame will start, and the stored byte count. The current page then moves on to the page after the last page the frame used, so software can follow the chain from one frame to the next.

A frame that would run into unread data is abandoned and reported as an overwrite and as a missed frame. The block also raises a sticky reset indication, which stays up until software writes the boundary. In monitor mode, frames are only counted as missed and nothing is stored.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, `memWe`, `ovwPulse`, `missedPulse` and `donePulse` are 0, and `curPage` and `rstFlag` are 0.
- R2: A register write (`cfgWe`=1) stores `cfgData` into the register that `cfgSel` picks: 0 sets the first ring page, 1 sets the page just past the ring, 2 sets the boundary, 3 sets the current page. A write with `cfgSel`=3 shows on `curPage` one cycle later.
- R3: Data byte i of a frame (counting from 0) is written at linear ring position 4+i, counted from the frame's first page. Position p lands on page first+p/PAGE_BYTES and offset p%PAGE_BYTES.
- R4: When a page pointer steps past the page below the ring's end page, it goes back to the ring's first page. This holds for the data write address, the header's link byte and `curPage`.
- R5: After the last byte and `rxEnd`, the block writes the header at the frame's first page. Offset 0 holds `rxStatus` as sampled with `rxEnd`. Offset 1 holds the link page. Offset 2 holds the low byte of (frame length + 4) and offset 3 holds its high byte.
- R6: The link page and the new `curPage` are both the page after the last page that holds a header or data byte of the frame. `donePulse` is high for exactly one cycle per stored frame.
- R7: The ring is full at a page q when the page after q equals the boundary. Starting a frame at a full current page, or moving its data into a full page, raises `ovwPulse` and `missedPulse` for one cycle each. The frame then gets no further memory writes and no header, and `curPage` does not change.
- R8: An overwrite sets `rstFlag`, and `rstFlag` stays set until a boundary register write clears it.
- R9: When `monitorMode` is 1 at `rxStart`, the frame makes no memory write, gives one `missedPulse`, leaves `curPage` alone and raises no `ovwPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select (0 first page, 1 end page, 2 boundary, 3 current) |
| cfgData | input | PAGE_W | Register write value |
| monitorMode | input | 1 | Check-only mode, nothing stored |
| rxStart | input | 1 | Frame start strobe |
| rxValid | input | 1 | Data byte strobe |
| rxData | input | 8 | Data byte |
| rxEnd | input | 1 | Frame end strobe |
| rxStatus | input | 8 | Receive status, sampled with rxEnd |
| memWe | output | 1 | Buffer memory write enable |
| memAddr | output | PAGE_W+OFF_W | Buffer memory byte address {page, offset} |
| memData | output | 8 | Buffer memory write data |
| curPage | output | PAGE_W | Current write page |
| ovwPulse | output | 1 | One-cycle overwrite event |
| missedPulse | output | 1 | One-cycle missed-frame event |
| donePulse | output | 1 | One-cycle frame-stored event |
| rstFlag | output | 1 | Sticky reset indication after overwrite |

## Verification
The bench builds the block with OFF_W=4, so each page is 16 bytes, and starts with a four-page ring. With pages this small, frames of only a few dozen bytes already span several pages, wrap around the ring end, and reach every overwrite point. The bench sweeps every frame length from 0 to 50 against every boundary distance from the current page, including a full ring at the start. A second, wider ring takes a 300-byte frame so that the high byte of the count field is non-zero.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int HDR_BYTES = 4;

  localparam logic [1:0] SEL_FIRST = 2'd0;
  localparam logic [1:0] SEL_END   = 2'd1;
  localparam logic [1:0] SEL_BND   = 2'd2;
  localparam logic [1:0] SEL_CUR   = 2'd3;

  typedef struct packed {
    logic       pktBegin;
    logic       putByte;
    logic       endPkt;
    logic       hdrWr;
    logic [1:0] hdrIdx;
    logic       commit;
    logic       ovf;
    logic       miss;
  } rxr_strobe_t;
endpackage

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [1:0]          cfgSel,
  input  logic [PAGE_W-1:0]   cfgData,
  input  logic [BYTE_W-1:0]   rxData,
  input  logic [BYTE_W-1:0]   rxStatus,
  input  rxr_strobe_t         stb,
  output logic                fullStart,
  output logic                fullEntry,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BYTE_W-1:0]   memData,
  output logic [PAGE_W-1:0]   curPage,
  output logic                rstFlag
);
  logic [PAGE_W-1:0] regFirst, regEnd, regBnd, regCur;
  logic [PAGE_W-1:0] wrPage, pktPage, linkPage;
  logic [OFF_W-1:0]  wrOff;
  logic [CNT_W-1:0]  byteCnt, hdrCnt;
  logic [BYTE_W-1:0] statByte;

  function automatic logic [PAGE_W-1:0] stepPage(input logic [PAGE_W-1:0] p,
      input logic [PAGE_W-1:0] first, input logic [PAGE_W-1:0] last);
    logic [PAGE_W-1:0] inc;
    inc = p + 1'b1;
    return (inc == last) ? first : inc;
  endfunction

  always_comb begin
    linkPage  = (wrOff == '0) ? wrPage : stepPage(wrPage, regFirst, regEnd);
    fullStart = stepPage(regCur, regFirst, regEnd) == regBnd;
    fullEntry = (wrOff == '0) && (stepPage(wrPage, regFirst, regEnd) == regBnd);
    hdrCnt    = byteCnt + CNT_W'(HDR_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regFirst <= '0; regEnd <= '0; regBnd <= '0; regCur <= '0;
      wrPage <= '0; pktPage <= '0; wrOff <= '0; byteCnt <= '0;
      statByte <= '0; memWe <= 1'b0; memAddr <= '0; memData <= '0;
      rstFlag <= 1'b0;
    end else begin
      memWe <= 1'b0;
      if (cfgWe) begin
        case (cfgSel)
          SEL_FIRST: regFirst <= cfgData;
          SEL_END:   regEnd   <= cfgData;
          SEL_BND: begin
            regBnd  <= cfgData;
            rstFlag <= 1'b0;
          end
          default:   regCur   <= cfgData;
        endcase
      end
      if (stb.ovf) rstFlag <= 1'b1;
      if (stb.pktBegin) begin
        pktPage <= regCur;
        wrPage  <= regCur;
        wrOff   <= OFF_W'(HDR_BYTES);
        byteCnt <= '0;
      end
      if (stb.putByte) begin
        memWe   <= 1'b1;
        memAddr <= {wrPage, wrOff};
        memData <= rxData;
        byteCnt <= byteCnt + 1'b1;
        wrOff   <= wrOff + 1'b1;
        if (wrOff == '1) wrPage <= stepPage(wrPage, regFirst, regEnd);
      end
      if (stb.endPkt) statByte <= rxStatus;
      if (stb.hdrWr) begin
        memWe   <= 1'b1;
        memAddr <= {pktPage, OFF_W'(stb.hdrIdx)};
        case (stb.hdrIdx)
          2'd0:    memData <= statByte;
          2'd1:    memData <= BYTE_W'(linkPage);
          2'd2:    memData <= hdrCnt[BYTE_W-1:0];
          default: memData <= hdrCnt[CNT_W-1:BYTE_W];
        endcase
      end
      if (stb.commit) regCur <= linkPage;
    end
  end

  assign curPage = regCur;
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        monitorMode,
  input  logic        rxStart,
  input  logic        rxValid,
  input  logic        rxEnd,
  input  logic        fullStart,
  input  logic        fullEntry,
  output rxr_strobe_t stb,
  output logic        ovwPulse,
  output logic        missedPulse,
  output logic        donePulse
);
  typedef enum logic [1:0] {S_IDLE, S_DATA, S_DROP, S_HDR} state_t;
  state_t state, nextState;
  logic [1:0] hdrCnt;

  always_comb begin
    stb = '0;
    nextState = state;
    case (state)
      S_IDLE: if (rxStart) begin
        if (monitorMode) begin
          stb.miss = 1'b1;
          nextState = S_DROP;
        end else if (fullStart) begin
          stb.ovf = 1'b1;
          stb.miss = 1'b1;
          nextState = S_DROP;
        end else begin
          stb.pktBegin = 1'b1;
          nextState = S_DATA;
        end
      end
      S_DATA: begin
        if (rxValid && fullEntry) begin
          stb.ovf = 1'b1;
          stb.miss = 1'b1;
          nextState = rxEnd ? S_IDLE : S_DROP;
        end else begin
          stb.putByte = rxValid;
          if (rxEnd) begin
            stb.endPkt = 1'b1;
            nextState = S_HDR;
          end
        end
      end
      S_DROP: if (rxEnd) nextState = S_IDLE;
      default: begin
        stb.hdrWr = 1'b1;
        stb.hdrIdx = hdrCnt;
        if (hdrCnt == 2'd3) begin
          stb.commit = 1'b1;
          nextState = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      hdrCnt <= '0;
      ovwPulse <= 1'b0;
      missedPulse <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      state <= nextState;
      hdrCnt <= (state == S_HDR) ? hdrCnt + 1'b1 : 2'd0;
      ovwPulse <= stb.ovf;
      missedPulse <= stb.miss;
      donePulse <= stb.commit;
    end
  end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [PAGE_W-1:0] cfgData,
  input  logic              monitorMode,
  input  logic              rxStart,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxEnd,
  input  logic [7:0]        rxStatus,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [PAGE_W-1:0] curPage,
  output logic              ovwPulse,
  output logic              missedPulse,
  output logic              donePulse,
  output logic              rstFlag
);
  rxr_strobe_t stb;
  logic fullStart, fullEntry;

  rxr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .monitorMode(monitorMode),
    .rxStart(rxStart), .rxValid(rxValid), .rxEnd(rxEnd),
    .fullStart(fullStart), .fullEntry(fullEntry), .stb(stb),
    .ovwPulse(ovwPulse), .missedPulse(missedPulse), .donePulse(donePulse)
  );

  rxr_datapath #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) dp_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .rxData(rxData), .rxStatus(rxStatus), .stb(stb),
    .fullStart(fullStart), .fullEntry(fullEntry),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .curPage(curPage), .rstFlag(rstFlag)
  );
endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [1:0]        cfgSel,
  input logic [PAGE_W-1:0] curPage,
  input logic              ovwPulse,
  input logic              missedPulse,
  input logic              donePulse,
  input logic              rstFlag
);
  // R7: every overwrite is also counted as a missed frame
  p_ovw_missed_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovwPulse |-> missedPulse);

  // R6 / R9: a frame ends either stored or missed, never both
  p_done_or_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({donePulse, missedPulse}));

  // R8: overwrite leaves the reset indication set
  p_ovw_sets_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovwPulse |-> rstFlag);

  // R8: the indication only drops after a boundary write
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstFlag) |-> $past(cfgWe && cfgSel == 2'd2));

  // R6 / R2: current page moves only on frame commit or a direct write
  p_cur_moves_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curPage) |-> (donePulse || $past(cfgWe && cfgSel == 2'd3)));
endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .curPage(curPage),
  .ovwPulse(ovwPulse), .missedPulse(missedPulse), .donePulse(donePulse),
  .rstFlag(rstFlag)
);

// File: tb/rx_ring_mgr_tb_top.sv
module rx_ring_mgr_tb_top;
  localparam int PAGE_W = 8;
  localparam int OFF_W  = 4;
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int PB     = 1 << OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [PAGE_W-1:0] cfgData = '0;
  logic monitorMode = 1'b0;
  logic rxStart = 1'b0, rxValid = 1'b0, rxEnd = 1'b0;
  logic [7:0] rxData = '0, rxStatus = '0;
  logic memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memData;
  logic [PAGE_W-1:0] curPage;
  logic ovwPulse, missedPulse, donePulse, rstFlag;

  int nChecks = 0, nFails = 0;
  int cntOvw = 0, cntMiss = 0, cntDone = 0, cntWe = 0;
  int pFirst = 0, pEnd = 0;
  logic [7:0] mem [0:(1<<ADDR_W)-1];

  always #10 clk = ~clk;

  rx_ring_mgr #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .monitorMode(monitorMode), .rxStart(rxStart), .rxValid(rxValid),
    .rxData(rxData), .rxEnd(rxEnd), .rxStatus(rxStatus),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .curPage(curPage),
    .ovwPulse(ovwPulse), .missedPulse(missedPulse), .donePulse(donePulse),
    .rstFlag(rstFlag)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (ovwPulse) cntOvw <= cntOvw + 1;
      if (missedPulse) cntMiss <= cntMiss + 1;
      if (donePulse) cntDone <= cntDone + 1;
      if (memWe) begin
        cntWe <= cntWe + 1;
        mem[memAddr] <= memData;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wrapAdd(input int p, input int k);
    return pFirst + ((p - pFirst + k) % (pEnd - pFirst));
  endfunction

  function automatic logic [7:0] dbyte(input int idx, input int i);
    return 8'(idx * 7 + i * 3 + 1);
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = PAGE_W'(val);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendPkt(input int len, input int idx, input logic [7:0] st);
    @(negedge clk);
    rxStart = 1'b1;
    @(negedge clk);
    rxStart = 1'b0;
    for (int i = 0; i < len; i++) begin
      rxValid = 1'b1; rxData = dbyte(idx, i);
      @(negedge clk);
    end
    rxValid = 1'b0; rxEnd = 1'b1; rxStatus = st;
    @(negedge clk);
    rxEnd = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  // Applies one frame and compares every effect against the arithmetic model.
  task automatic runPkt(input int len, input int idx);
    int s, need, failK, o0, m0, d0, w0, cnt, lastNext;
    logic [7:0] st;
    s = int'(curPage);
    st = 8'(idx * 13 + 5);
    need = (HDR_LEN + len + PB - 1) / PB;
    failK = -1;
    for (int k = 0; k < need; k++) begin
      if (failK < 0 && wrapAdd(wrapAdd(s, k), 1) == int'(dut_i.dp_i.regBnd)) failK = k;
    end
    o0 = cntOvw; m0 = cntMiss; d0 = cntDone; w0 = cntWe;
    sendPkt(len, idx, st);
    if (failK >= 0) begin
      check(cntOvw - o0 == 1, "R7 overwrite pulse", cntOvw - o0, 1);
      check(cntMiss - m0 == 1, "R7 missed pulse", cntMiss - m0, 1);
      check(cntDone == d0, "R7 no commit", cntDone - d0, 0);
      check(int'(curPage) == s, "R7 current kept", curPage, s);
      check(cntWe - w0 == ((failK == 0) ? 0 : failK * PB - HDR_LEN),
            "R7 writes before stop", cntWe - w0, (failK == 0) ? 0 : failK * PB - HDR_LEN);
      check(rstFlag == 1'b1, "R8 flag set", rstFlag, 1);
    end else begin
      lastNext = wrapAdd(s, need);
      cnt = len + HDR_LEN;
      check(cntOvw == o0 && cntMiss == m0, "R7 no false overwrite", cntOvw - o0, 0);
      check(cntDone - d0 == 1, "R6 done pulse", cntDone - d0, 1);
      check(cntWe - w0 == len + HDR_LEN, "R5 write count", cntWe - w0, len + HDR_LEN);
      check(int'(curPage) == lastNext, "R6 R4 current advance", curPage, lastNext);
      check(mem[s*PB+0] == st, "R5 status byte", mem[s*PB+0], st);
      check(int'(mem[s*PB+1]) == lastNext, "R5 R4 link byte", mem[s*PB+1], lastNext);
      check(int'(mem[s*PB+2]) == (cnt & 255), "R5 count low", mem[s*PB+2], cnt & 255);
      check(int'(mem[s*PB+3]) == (cnt >> 8), "R5 count high", mem[s*PB+3], cnt >> 8);
      for (int i = 0; i < len; i++) begin
        int pos, a;
        pos = HDR_LEN + i;
        a = wrapAdd(s, pos / PB) * PB + pos % PB;
        check(mem[a] == dbyte(idx, i), "R3 R4 data byte", mem[a], dbyte(idx, i));
      end
    end
  endtask

  localparam int HDR_LEN = 4;

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    check(memWe == 0 && ovwPulse == 0 && missedPulse == 0 && donePulse == 0,
          "R1 reset strobes", memWe, 0);
    check(curPage == 0 && rstFlag == 0, "R1 reset regs", curPage, 0);
    rstN = 1'b1;
    pFirst = 2; pEnd = 6;
    cfgWrite(2'd0, pFirst);
    cfgWrite(2'd1, pEnd);
    cfgWrite(2'd3, 5);
    check(curPage == 5, "R2 current write", curPage, 5);
    cfgWrite(2'd3, 2);
    check(curPage == 2, "R2 current rewrite", curPage, 2);
    cfgWrite(2'd2, 2);

    // R9: monitor mode stores nothing
    begin
      int m0, w0, o0;
      m0 = cntMiss; w0 = cntWe; o0 = cntOvw;
      monitorMode = 1'b1;
      sendPkt(5, 99, 8'h11);
      monitorMode = 1'b0;
      check(cntMiss - m0 == 1, "R9 missed", cntMiss - m0, 1);
      check(cntWe == w0, "R9 no writes", cntWe - w0, 0);
      check(cntOvw == o0, "R9 no overwrite", cntOvw - o0, 0);
      check(curPage == 2, "R9 current kept", curPage, 2);
    end

    for (int b = 0; b < 4; b++) begin
      for (int len = 0; len <= 50; len++) begin
        cfgWrite(2'd2, wrapAdd(int'(curPage), b));
        check(rstFlag == 1'b0, "R8 flag cleared by boundary write", rstFlag, 0);
        runPkt(len, idx);
        idx++;
      end
    end

    // wider ring: count field high byte non-zero
    pFirst = 16; pEnd = 40;
    cfgWrite(2'd0, pFirst);
    cfgWrite(2'd1, pEnd);
    cfgWrite(2'd3, 38);
    cfgWrite(2'd2, 38);
    runPkt(300, idx);
    finish();
  end
endmodule